// File: doc/BRIEF.md
# Strip-Mined Vector Length Sequencer

This block splits a vector operation of arbitrary total length N into pieces that each fit within the hardware maximum vector length (MVL). A start pulse latches N and a base element index. The block then emits one chunk descriptor per cycle over a valid/ready handshake. Each descriptor holds the vector length to program for that chunk and the index of the chunk's first element. A downstream vector unit consumes the descriptors and does the element arithmetic. This block does no arithmetic on the elements.

The odd-sized piece, N modulo MVL, is issued first. Every later chunk is exactly MVL elements long, and each start index follows on from the one before it. The final descriptor is flagged as last. A one-cycle done pulse follows its handshake.

Top module: `vl_strip_seq`

## Requirements
- R1: After reset, desc_valid_o, done_o and busy_o are all 0.
- R2: When N mod MVL is non-zero, the first descriptor has length N mod MVL and start index equal to the latched base index. Every descriptor length lies in 1..MVL.
- R3: When N is a non-zero multiple of MVL, the first descriptor has length MVL, and no zero-length descriptor is ever produced.
- R4: Every descriptor after the first has length exactly MVL.
- R5: The start index of each descriptor after the first equals the previous start index plus the previous length.
- R6: The sequence has exactly N/MVL + (N mod MVL != 0 ? 1 : 0) descriptors. desc_last_o is 1 on the final descriptor and 0 on every other one.
- R7: When N is 0, done_o is 1 in the cycle after the start is accepted, and no descriptor is presented.
- R8: While desc_valid_o is 1 and desc_ready_i is 0, the descriptor fields stay unchanged and valid stays high.
- R9: done_o is a single-cycle pulse in the cycle after the handshake of the last descriptor. desc_valid_o is 0 while done_o is 1.
- R10: start_i is ignored while busy_o is 1. busy_o rises the cycle after an accepted start and stays high through the done cycle. A start pulsed mid-sequence changes no descriptor and starts no new sequence.
- R11: After the handshake of a non-last descriptor, the next descriptor is valid in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, accepted only when idle |
| total_len_i | input | LEN_W | Total element count N, latched at start |
| base_idx_i | input | IDX_W | Index of the first element, latched at start |
| desc_ready_i | input | 1 | Consumer ready for a descriptor |
| desc_valid_o | output | 1 | Descriptor valid |
| desc_vl_o | output | VL_W | Vector length for this chunk (VL_W = clog2(MVL+1)) |
| desc_start_o | output | IDX_W | Start element index of this chunk |
| desc_last_o | output | 1 | Marks the final descriptor of the sequence |
| done_o | output | 1 | One-cycle pulse when the sequence is complete |
| busy_o | output | 1 | A sequence is in progress |

## Verification
The assertions check several per-cycle rules on every cycle:
- each length stays in range;
- the descriptor is held steady under back-pressure;
- after each non-last handshake, the length switches to MVL, the index advances by the previous length, and the next descriptor follows at once;
- done pulses once after the last handshake;
- an empty request finishes at once.

Only the bench scenarios can show whole-sequence properties. These are the exact number of chunks for a given N, the remainder-first order, the correct placement of the last flag, and the fact that a stray start mid-sequence leaves the sequence untouched. The bench covers these for several lengths, base indices and ready patterns.

// File: rtl/vl_seq_pkg.sv
// Shared types for the strip-mined vector length sequencer.
package vl_seq_pkg;
    // Sequencer phases: waiting, emitting descriptors, signalling completion.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_EMIT = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/vl_chunk_plan.sv
// Chunk planner: from a total element count, works out the length of the
// first chunk (the remainder, or a full MVL when the remainder is zero),
// the total number of chunks, and whether the request is empty.
// This logic is purely combinational.
// Assumes LEN_W >= VL_W.
// A power-of-two MVL uses a mask and shift. Any other MVL uses divide and modulo by a constant.
module vl_chunk_plan #(
    parameter int MVL   = 64,
    parameter int LEN_W = 16,
    parameter int VL_W  = $clog2(MVL + 1)
) (
    input  logic [LEN_W-1:0] total_len,
    output logic [VL_W-1:0]  first_vl,
    output logic [LEN_W-1:0] chunk_cnt,
    output logic             is_empty
);
    localparam bit POW2  = ((MVL & (MVL - 1)) == 0);
    localparam int SHIFT = (MVL > 1) ? $clog2(MVL) : 0;

    logic [LEN_W-1:0] rem_len;
    logic [LEN_W-1:0] full_cnt;

    generate
        if (POW2) begin : g_pow2
            // Remainder and quotient by masking and shifting.
            always_comb begin
                rem_len  = total_len & LEN_W'(MVL - 1);
                full_cnt = total_len >> SHIFT;
            end
        end else begin : g_div
            // Remainder and quotient by constant division.
            always_comb begin
                rem_len  = total_len % LEN_W'(MVL);
                full_cnt = total_len / LEN_W'(MVL);
            end
        end
    endgenerate

    // First chunk length, chunk count and empty flag.
    always_comb begin
        first_vl  = (rem_len != '0) ? VL_W'(rem_len) : VL_W'(MVL);
        chunk_cnt = full_cnt + LEN_W'(rem_len != '0);
        is_empty  = (total_len == '0);
    end
endmodule

// File: rtl/vl_seq_fsm.sv
// Sequence controller. It accepts a start only when idle and moves to emission or straight to
// completion for an empty request. It leaves emission after the last handshake.
// It holds completion for exactly one cycle before returning to idle.
module vl_seq_fsm
    import vl_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       is_empty,
    input  logic       handshake,
    input  logic       last_chunk,
    output seq_state_e state,
    output logic       load
);
    seq_state_e state_q;

    // Descriptor registers load on an accepted non-empty start.
    always_comb load = (state_q == SEQ_IDLE) && start && !is_empty;

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            unique case (state_q)
                SEQ_IDLE: if (start) state_q <= is_empty ? SEQ_DONE : SEQ_EMIT;
                SEQ_EMIT: if (handshake && last_chunk) state_q <= SEQ_DONE;
                SEQ_DONE: state_q <= SEQ_IDLE;
                default:  state_q <= SEQ_IDLE;
            endcase
        end
    end

    always_comb state = state_q;
endmodule

// File: rtl/vl_desc_gen.sv
// Descriptor generator. It holds the current chunk length, start index and
// remaining chunk count. On load it takes the planned first chunk. On advance it
// moves the index past the current chunk and resets the length to MVL.
// Assumes advance is never raised on the last chunk.
module vl_desc_gen #(
    parameter int MVL   = 64,
    parameter int LEN_W = 16,
    parameter int IDX_W = 16,
    parameter int VL_W  = $clog2(MVL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             advance,
    input  logic [VL_W-1:0]  first_vl,
    input  logic [LEN_W-1:0] chunk_cnt,
    input  logic [IDX_W-1:0] base_idx,
    output logic [VL_W-1:0]  cur_vl,
    output logic [IDX_W-1:0] cur_idx,
    output logic             is_last
);
    logic [LEN_W-1:0] left_q;

    // Chunk registers: load the first chunk, then step one chunk per advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_vl  <= '0;
            cur_idx <= '0;
            left_q  <= '0;
        end else if (load) begin
            cur_vl  <= first_vl;
            cur_idx <= base_idx;
            left_q  <= chunk_cnt;
        end else if (advance) begin
            cur_idx <= cur_idx + IDX_W'(cur_vl);
            cur_vl  <= VL_W'(MVL);
            left_q  <= left_q - 1'b1;
        end
    end

    // The final chunk is the one with a single chunk left.
    always_comb is_last = (left_q == LEN_W'(1));
endmodule

// File: rtl/vl_strip_seq.sv
// Strip-mined vector length sequencer top. It splits N elements into a
// remainder-first series of chunks of at most MVL elements each. It offers them as
// valid/ready descriptors and pulses done after the final one.
// Assumes the index arithmetic fits in IDX_W.
module vl_strip_seq
    import vl_seq_pkg::*;
#(
    parameter int MVL   = 64,
    parameter int LEN_W = 16,
    parameter int IDX_W = 16,
    localparam int VL_W = $clog2(MVL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] total_len_i,
    input  logic [IDX_W-1:0] base_idx_i,
    input  logic             desc_ready_i,
    output logic             desc_valid_o,
    output logic [VL_W-1:0]  desc_vl_o,
    output logic [IDX_W-1:0] desc_start_o,
    output logic             desc_last_o,
    output logic             done_o,
    output logic             busy_o
);
    logic [VL_W-1:0]  first_vl;
    logic [LEN_W-1:0] chunk_cnt;
    logic             is_empty;
    logic             load;
    logic             handshake;
    logic             is_last;
    seq_state_e       state;

    vl_chunk_plan #(.MVL(MVL), .LEN_W(LEN_W), .VL_W(VL_W)) u_plan (
        .total_len (total_len_i),
        .first_vl  (first_vl),
        .chunk_cnt (chunk_cnt),
        .is_empty  (is_empty)
    );

    vl_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_i),
        .is_empty   (is_empty),
        .handshake  (handshake),
        .last_chunk (is_last),
        .state      (state),
        .load       (load)
    );

    vl_desc_gen #(.MVL(MVL), .LEN_W(LEN_W), .IDX_W(IDX_W), .VL_W(VL_W)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .advance   (handshake && !is_last),
        .first_vl  (first_vl),
        .chunk_cnt (chunk_cnt),
        .base_idx  (base_idx_i),
        .cur_vl    (desc_vl_o),
        .cur_idx   (desc_start_o),
        .is_last   (is_last)
    );

    // Handshake and output flags derived from the controller state.
    always_comb begin
        desc_valid_o = (state == SEQ_EMIT);
        handshake    = desc_valid_o && desc_ready_i;
        desc_last_o  = desc_valid_o && is_last;
        done_o       = (state == SEQ_DONE);
        busy_o       = (state != SEQ_IDLE);
    end
endmodule

// File: rtl/vl_strip_seq_chk.sv
// Protocol checker for the sequencer. It watches ports only and is bound to every instance of the top.
module vl_strip_seq_chk #(
    parameter int MVL   = 64,
    parameter int LEN_W = 16,
    parameter int IDX_W = 16,
    parameter int VL_W  = $clog2(MVL + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [LEN_W-1:0] total_len_i,
    input logic             desc_ready_i,
    input logic             desc_valid_o,
    input logic [VL_W-1:0]  desc_vl_o,
    input logic [IDX_W-1:0] desc_start_o,
    input logic             desc_last_o,
    input logic             done_o,
    input logic             busy_o
);
    // R2
    vl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid_o |-> (desc_vl_o != '0) && (desc_vl_o <= VL_W'(MVL)));
    // R3
    exact_multiple_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && total_len_i != '0 && (total_len_i % LEN_W'(MVL)) == '0)
        |=> desc_vl_o == VL_W'(MVL));
    // R4
    full_after_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid_o && desc_ready_i && !desc_last_o) |=> desc_vl_o == VL_W'(MVL));
    // R5
    idx_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid_o && desc_ready_i && !desc_last_o)
        |=> desc_start_o == $past(desc_start_o) + IDX_W'($past(desc_vl_o)));
    // R7
    empty_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && total_len_i == '0) |=> done_o && !desc_valid_o);
    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid_o && !desc_ready_i)
        |=> desc_valid_o && $stable(desc_vl_o) && $stable(desc_start_o) && $stable(desc_last_o));
    // R9
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid_o && desc_ready_i && desc_last_o) |=> done_o && !desc_valid_o);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);
    // R11
    back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid_o && desc_ready_i && !desc_last_o) |=> desc_valid_o);
endmodule

bind vl_strip_seq vl_strip_seq_chk #(
    .MVL(MVL), .LEN_W(LEN_W), .IDX_W(IDX_W), .VL_W(VL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .total_len_i  (total_len_i),
    .desc_ready_i (desc_ready_i),
    .desc_valid_o (desc_valid_o),
    .desc_vl_o    (desc_vl_o),
    .desc_start_o (desc_start_o),
    .desc_last_o  (desc_last_o),
    .done_o       (done_o),
    .busy_o       (busy_o)
);

// File: tb/tb_vl_strip_seq.sv
`timescale 1ns/1ps
module tb_vl_strip_seq;
    localparam int M     = 8;
    localparam int LEN_W = 12;
    localparam int IDX_W = 12;
    localparam int VL_W  = $clog2(M + 1);
    localparam int NVEC  = 11;
    // Each vector packs {stall, N[11:0], base[11:0]}.
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b0, 12'd1,   12'd1},
        {1'b0, 12'd8,   12'd1},
        {1'b0, 12'd9,   12'd1},
        {1'b1, 12'd16,  12'd1},
        {1'b0, 12'd21,  12'd0},
        {1'b1, 12'd7,   12'd100},
        {1'b0, 12'd64,  12'd5},
        {1'b1, 12'd65,  12'd1},
        {1'b0, 12'd3,   12'd4000},
        {1'b1, 12'd24,  12'd1},
        {1'b0, 12'd100, 12'd1}
    };

    logic             clk = 0;
    logic             rst_n = 0;
    logic             start_i = 0;
    logic [LEN_W-1:0] total_len_i = '0;
    logic [IDX_W-1:0] base_idx_i = '0;
    logic             desc_ready_i = 0;
    logic             desc_valid_o;
    logic [VL_W-1:0]  desc_vl_o;
    logic [IDX_W-1:0] desc_start_o;
    logic             desc_last_o;
    logic             done_o;
    logic             busy_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    vl_strip_seq #(.MVL(M), .LEN_W(LEN_W), .IDX_W(IDX_W)) dut (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs one sequence. Expected values come from the requirements; a poke
    // pulses a different start mid-sequence (R10).
    task automatic run_seq(input int n, input int base, input bit stall, input bit poke);
        int  cnt, first, k, cyc;
        bit  hs, last_hs;
        cnt   = n / M + ((n % M) != 0 ? 1 : 0);
        first = ((n % M) != 0) ? (n % M) : M;
        k = 0; cyc = 0; last_hs = 0;
        @(negedge clk);
        start_i = 1; total_len_i = LEN_W'(n); base_idx_i = IDX_W'(base);
        @(negedge clk);
        start_i = 0; total_len_i = LEN_W'(5);
        check(busy_o == 1'b1, "R10 busy after start", busy_o, 1);
        forever begin
            start_i = poke && (k == 1);
            if (last_hs || cnt == 0) begin
                check(done_o == 1'b1, cnt == 0 ? "R7 empty done" : "R9 done after last", done_o, 1);
            end
            if (done_o) begin
                check(k == cnt, "R6 chunk count", k, cnt);
                check(desc_valid_o == 1'b0, "R9 valid low at done", desc_valid_o, 0);
                break;
            end
            if (k > 0 && k < cnt) check(desc_valid_o == 1'b1, "R11 next chunk valid", desc_valid_o, 1);
            hs = 0;
            if (desc_valid_o) begin
                int exp_vl, exp_idx;
                exp_vl  = (k == 0) ? first : M;
                exp_idx = (base + ((k == 0) ? 0 : first + (k - 1) * M)) % (1 << IDX_W);
                check(int'(desc_vl_o) == exp_vl,
                      k == 0 ? ((n % M) != 0 ? "R2 first length" : "R3 multiple first length")
                             : "R4 full length", desc_vl_o, exp_vl);
                check(int'(desc_start_o) == exp_idx, k == 0 ? "R2 base index" : "R5 index step",
                      desc_start_o, exp_idx);
                check(desc_last_o == (k == cnt - 1), "R6 last flag", desc_last_o, k == cnt - 1);
                desc_ready_i = stall ? cyc[0] : 1'b1;  // stalled cycles recheck same k (R8)
                hs = desc_ready_i;
            end else begin
                desc_ready_i = 0;
            end
            @(posedge clk);
            last_hs = hs && (k == cnt - 1);
            if (hs) k++;
            @(negedge clk);
            cyc++;
            if (cyc > 2000) begin
                check(0, "R6 sequence timeout", k, cnt);
                break;
            end
        end
        start_i = 0; desc_ready_i = 0;
        @(negedge clk);
        check(busy_o == 1'b0 && done_o == 1'b0, "R9 single done pulse", done_o, 0);
        if (poke) begin
            @(negedge clk);
            check(desc_valid_o == 1'b0 && busy_o == 1'b0, "R10 stray start ignored", desc_valid_o, 0);
        end
    endtask

    initial begin
        #(200000 * 8);
        check(0, "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(desc_valid_o == 0, "R1 valid in reset", desc_valid_o, 0);
        check(done_o == 0, "R1 done in reset", done_o, 0);
        check(busy_o == 0, "R1 busy in reset", busy_o, 0);
        rst_n = 1;
        @(negedge clk);
        check(desc_valid_o == 0 && busy_o == 0, "R1 idle after reset", busy_o, 0);
        for (int i = 0; i < NVEC; i++) begin
            run_seq(int'(VEC[i][23:12]), int'(VEC[i][11:0]), VEC[i][24], 1'b0);
        end
        // R7 empty request
        run_seq(0, 1, 1'b0, 1'b0);
        // R10 stray start during sequences, with and without stalls
        run_seq(30, 2, 1'b0, 1'b1);
        run_seq(19, 7, 1'b1, 1'b1);
        // R1 reset mid-sequence returns to idle
        @(negedge clk);
        start_i = 1; total_len_i = LEN_W'(40); base_idx_i = '0;
        @(negedge clk);
        start_i = 0; rst_n = 0;
        @(negedge clk);
        check(desc_valid_o == 0 && busy_o == 0, "R1 reset aborts", busy_o, 0);
        rst_n = 1;
        run_seq(17, 3, 1'b1, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule